// File: doc/BRIEF.md
# Multichannel serial audio input packer

This block gathers up to eight serial audio streams and puts them into one shared queue. Each stream arrives on its own bit clock, frame sync and data pin. Each lane turns its stream back into left and right samples, using the sample width that its mode field selects. A finished sample becomes a self-describing 32-bit word:

- the sample, placed at the top of the word;
- zero fill down to bit 4;
- a left/right flag;
- the number of the lane that produced it.

Finished words cross from their bit clock into the system clock through a toggle handshake. A rotating arbiter then writes at most one word per system cycle into a 16-entry queue, which software-side logic drains through a show-ahead pop port.

A lane whose clocks stay low, or whose mode field holds a disabled code, puts nothing into the queue. A word that finds the queue full is discarded, and a sticky overflow flag records the loss.

The mode fields are read directly in each bit clock domain. They must therefore be changed only while the lanes concerned are idle.

Top module: `audio_rx_packer`

## Requirements
- R1: After reset the queue is empty (`fifoEmpty`=1, `fifoLevel`=0, `fifoFull`=0) and `overflow` is 0.
- R2: The mode of lane c is `ctrlWord[8+3c+2 : 8+3c]`. Code 0 selects 24-bit samples, 1 selects 20-bit, 2 selects 18-bit and 3 selects 16-bit; `ctrlWord[7:0]` has no effect.
- R3: A packed word holds the N-bit sample in bits 31 down to 32-N, with zeros from there down to bit 4.
- R4: Bit 3 of a word is 1 for a sample taken while frame sync was high (left) and 0 for one taken while frame sync was low (right). Bits 2:0 hold the lane number.
- R5: Data is sampled on the rising bit clock edge, most significant bit first. The sample is the last N bits sampled before the edge at which frame sync is first seen at its new level; the bit sampled at that edge belongs to the next half.
- R6: The first frame sync change a lane sees after reset only aligns it and produces no word.
- R7: A lane with mode code 4 to 7 produces no words, whatever its frame sync does.
- R8: Words that become ready in the same cycle are written in rotating order, starting after the lane granted last. After reset lane 0 comes first.
- R9: The queue holds 16 words in arrival order. `popData` shows the oldest word while the queue is not empty, `popReq` removes it at the next system edge, `fifoLevel` gives the count, and `fifoFull` is 1 at 16.
- R10: A word that arrives while the queue is full is discarded and leaves the stored words unchanged. It sets `overflow`, which then stays 1 until reset.
- R11: `popReq` while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock for the crossing, arbiter and queue |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| ctrlWord | input | 32 | Per-lane 3-bit mode fields in bits 31:8 |
| bitClk | input | 8 | Bit clock of each lane |
| frameSync | input | 8 | Frame sync of each lane |
| serData | input | 8 | Serial data of each lane |
| popReq | input | 1 | Remove the word shown on popData |
| popData | output | 32 | Oldest queued word |
| fifoEmpty | output | 1 | Queue holds no word |
| fifoFull | output | 1 | Queue holds 16 words |
| fifoLevel | output | 5 | Number of queued words |
| overflow | output | 1 | Sticky flag: a word was discarded |

## Verification
A word is registered at the bit clock edge that ends its half-frame. It then passes through two synchronizer stages and a pending register before it is granted. It therefore reaches the queue about four system cycles later, plus up to seven more cycles when all lanes finish together. The bench waits thirty system cycles after the last serial edge of every stimulus before it reads `fifoLevel`, `fifoFull` or `overflow`. All of those are registered outputs and are settled by then. Pops and samples happen on falling system edges, so each popped word is compared one full cycle after the previous removal.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int NCH   = 8;
  localparam int CHW   = 3;
  localparam int MODEW = 3;
  localparam int WORDW = 32;
  localparam int SAMPW = 24;
  localparam int FILLW = WORDW - SAMPW - 1 - CHW;

  typedef struct packed {
    logic [NCH-1:0] load;   // copy hold word of lane into pending slot
    logic           wrEn;   // write granted pending word into queue
    logic [CHW-1:0] wrSel;  // lane whose pending word is written
    logic           rdEn;   // advance queue head
  } strobe_t;

  // shift-register tail is the sample; move it to the top of the field
  function automatic logic [WORDW-1:0] packWord(input logic [SAMPW-1:0] sh,
                                                input logic [1:0] widthSel,
                                                input logic lr,
                                                input logic [CHW-1:0] ch);
    logic [SAMPW-1:0] s;
    case (widthSel)
      2'd0:    s = sh;
      2'd1:    s = {sh[19:0], 4'b0};
      2'd2:    s = {sh[17:0], 6'b0};
      default: s = {sh[15:0], 8'b0};
    endcase
    return {s, {FILLW{1'b0}}, lr, ch};
  endfunction
endpackage

// File: rtl/rxpk_lane.sv
module rxpk_lane import rxpk_pkg::*; #(
  parameter logic [CHW-1:0] CH_ID = '0
) (
  input  logic             bitClk,
  input  logic             rstN,
  input  logic             fs,
  input  logic             dat,
  input  logic [MODEW-1:0] mode,
  output logic [WORDW-1:0] holdWord,
  output logic             tog
);
  logic [SAMPW-1:0] sh;
  logic fsPrev, primed;
  logic modeOn;

  assign modeOn = ~mode[MODEW-1];

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      sh       <= '0;
      fsPrev   <= 1'b0;
      primed   <= 1'b0;
      tog      <= 1'b0;
      holdWord <= '0;
    end else begin
      sh     <= {sh[SAMPW-2:0], dat};
      fsPrev <= fs;
      if (fs != fsPrev) begin
        primed <= 1'b1;
        if (primed && modeOn) begin
          holdWord <= packWord(sh, mode[1:0], fsPrev, CH_ID);
          tog      <= ~tog;
        end
      end
    end
  end

  // R7: a disabled lane never signals a new word
  assert_disabled_quiet_R7: assert property (@(posedge bitClk) disable iff (!rstN)
    $past(mode[MODEW-1]) |-> $stable(tog));
endmodule

// File: rtl/rxpk_ctl.sv
module rxpk_ctl import rxpk_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic           sysClk,
  input  logic           rstN,
  input  logic [NCH-1:0] tog,
  input  logic           popReq,
  output strobe_t        stb,
  output logic [LW-1:0]  level,
  output logic           empty,
  output logic           full,
  output logic           ovf
);
  logic [NCH-1:0] s1, s2, s3, arrive, pend, grant;
  logic [CHW-1:0] lastGnt, gIdx;
  logic found, wrEn, rdEn;

  assign arrive = s2 ^ s3;
  assign empty  = (level == '0);
  assign full   = (level == LW'(DEPTH));

  always_comb begin
    logic [CHW-1:0] idx;
    grant = '0;
    gIdx  = lastGnt;
    found = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      idx = lastGnt + CHW'(k);
      if (pend[idx] && !found) begin
        grant[idx] = 1'b1;
        gIdx       = idx;
        found      = 1'b1;
      end
    end
  end

  assign wrEn = found && !full;
  assign rdEn = popReq && !empty;

  always_comb begin
    stb.load  = arrive;
    stb.wrEn  = wrEn;
    stb.wrSel = gIdx;
    stb.rdEn  = rdEn;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      pend    <= '0;
      lastGnt <= '1;
      level   <= '0;
      ovf     <= 1'b0;
    end else begin
      s1 <= tog; s2 <= s1; s3 <= s2;
      pend <= (pend & ~grant) | arrive;
      if (found) lastGnt <= gIdx;
      if (found && full) ovf <= 1'b1;
      level <= level + LW'(wrEn) - LW'(rdEn);
    end
  end

  // R9: the count never passes the queue depth
  assert_level_bound_R9: assert property (@(posedge sysClk) disable iff (!rstN)
    level <= LW'(DEPTH));
  // R10: nothing is written into a full queue, and a drop raises the flag
  assert_no_write_full_R10: assert property (@(posedge sysClk) disable iff (!rstN)
    stb.wrEn |-> !full);
  assert_drop_flags_R10: assert property (@(posedge sysClk) disable iff (!rstN)
    (found && full) |=> ovf);
  assert_ovf_sticky_R10: assert property (@(posedge sysClk) disable iff (!rstN)
    ovf |=> ovf);
  // R8: at most one lane is served per cycle
  assert_one_grant_R8: assert property (@(posedge sysClk) disable iff (!rstN)
    $onehot0(grant));
  // R11: no removal from an empty queue
  assert_no_pop_empty_R11: assert property (@(posedge sysClk) disable iff (!rstN)
    stb.rdEn |-> !empty);
endmodule

// File: rtl/rxpk_dp.sv
module rxpk_dp import rxpk_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 sysClk,
  input  logic                 rstN,
  input  logic [NCH-1:0]       bitClk,
  input  logic [NCH-1:0]       fs,
  input  logic [NCH-1:0]       dat,
  input  logic [NCH*MODEW-1:0] modeBits,
  input  strobe_t              stb,
  output logic [NCH-1:0]       tog,
  output logic [WORDW-1:0]     headWord
);
  logic [WORDW-1:0] holdWord [NCH];
  logic [WORDW-1:0] pendWord [NCH];
  logic [WORDW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  for (genvar i = 0; i < NCH; i++) begin : gLane
    rxpk_lane #(.CH_ID(CHW'(i))) uLane (
      .bitClk  (bitClk[i]),
      .rstN    (rstN),
      .fs      (fs[i]),
      .dat     (dat[i]),
      .mode    (modeBits[MODEW*i +: MODEW]),
      .holdWord(holdWord[i]),
      .tog     (tog[i])
    );
  end

  always_ff @(posedge sysClk) begin
    for (int i = 0; i < NCH; i++)
      if (stb.load[i]) pendWord[i] <= holdWord[i];
    if (stb.wrEn) mem[wrPtr] <= pendWord[stb.wrSel];
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.wrEn) wrPtr <= wrPtr + 1'b1;
      if (stb.rdEn) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign headWord = mem[rdPtr];
endmodule

// File: rtl/audio_rx_packer.sv
module audio_rx_packer import rxpk_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic [WORDW-1:0] ctrlWord,
  input  logic [NCH-1:0]   bitClk,
  input  logic [NCH-1:0]   frameSync,
  input  logic [NCH-1:0]   serData,
  input  logic             popReq,
  output logic [WORDW-1:0] popData,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic [LW-1:0]    fifoLevel,
  output logic             overflow
);
  strobe_t stb;
  logic [NCH-1:0] tog;
  logic unusedCtrlLow;

  assign unusedCtrlLow = ^ctrlWord[WORDW-NCH*MODEW-1:0];

  rxpk_ctl #(.DEPTH(DEPTH)) uCtl (
    .sysClk(sysClk), .rstN(rstN), .tog(tog), .popReq(popReq),
    .stb(stb), .level(fifoLevel), .empty(fifoEmpty), .full(fifoFull),
    .ovf(overflow)
  );

  rxpk_dp #(.DEPTH(DEPTH)) uDp (
    .sysClk(sysClk), .rstN(rstN), .bitClk(bitClk), .fs(frameSync),
    .dat(serData), .modeBits(ctrlWord[WORDW-1:WORDW-NCH*MODEW]),
    .stb(stb), .tog(tog), .headWord(popData)
  );
endmodule

// File: tb/audio_rx_packer_test.sv
module audio_rx_packer_test;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_PERIOD = 40;
  localparam int SETTLE = 30;

  // entry: lane(3) mode(2) left(24) right(24)
  localparam logic [52:0] VEC [8] = '{
    {3'd0, 2'd0, 24'hA5C3F1, 24'h13579B},
    {3'd1, 2'd1, 24'h0F1E2D, 24'hFEDCBA},
    {3'd2, 2'd2, 24'h3FFFF1, 24'h200002},
    {3'd3, 2'd3, 24'h00BEEF, 24'h00CAFE},
    {3'd4, 2'd0, 24'h800001, 24'h7FFFFE},
    {3'd5, 2'd3, 24'h12FFFF, 24'h348001},
    {3'd6, 2'd1, 24'hF80000, 24'h0FFFFF},
    {3'd7, 2'd2, 24'h01ABCD, 24'h02DCBA}
  };

  logic sysClk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [7:0] bitClk = '0, frameSync = '0, serData = '0;
  logic popReq = 1'b0;
  logic [31:0] popData;
  logic fifoEmpty, fifoFull, overflow;
  logic [4:0] fifoLevel;
  int checks = 0;
  int errors = 0;

  audio_rx_packer uut (
    .sysClk(sysClk), .rstN(rstN), .ctrlWord(ctrlWord), .bitClk(bitClk),
    .frameSync(frameSync), .serData(serData), .popReq(popReq),
    .popData(popData), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .fifoLevel(fifoLevel), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) sysClk = ~sysClk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [23:0] val, input int n,
                                          input logic lr, input logic [2:0] ch);
    logic [31:0] w;
    w = (32'(val) & ((32'd1 << n) - 1)) << (32 - n);
    w[3] = lr;
    w[2:0] = ch;
    return w;
  endfunction

  function automatic int widthOf(input logic [1:0] m);
    case (m)
      2'd0: return 24;
      2'd1: return 20;
      2'd2: return 18;
      default: return 16;
    endcase
  endfunction

  task automatic bitOut(input logic [7:0] mask, input logic fsv, input logic d);
    frameSync = (frameSync & ~mask) | (fsv ? mask : 8'h00);
    serData   = (serData & ~mask) | (d ? mask : 8'h00);
    #(BIT_PERIOD/2);
    bitClk = bitClk | mask;
    #(BIT_PERIOD/2);
    bitClk = bitClk & ~mask;
  endtask

  task automatic sendHalf(input logic [7:0] mask, input logic fsv,
                          input logic [23:0] val, input int n);
    for (int j = 0; j < 32; j++)
      bitOut(mask, fsv, (j < 32 - n) ? 1'b0 : val[n - 1 - (j - (32 - n))]);
  endtask

  task automatic frame(input logic [7:0] mask, input logic [23:0] l,
                       input logic [23:0] r, input int n);
    sendHalf(mask, 1'b1, l, n);
    sendHalf(mask, 1'b0, r, n);
    bitOut(mask, 1'b1, 1'b0);
    repeat (SETTLE) @(posedge sysClk);
  endtask

  task automatic popCheck(input string req, input logic [31:0] exp);
    @(negedge sysClk);
    check(req, popData, exp);
    popReq = 1'b1;
    @(negedge sysClk);
    popReq = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge sysClk);
    check("R1 empty", 32'(fifoEmpty), 32'd1);
    check("R1 level", 32'(fifoLevel), 32'd0);
    check("R1 full", 32'(fifoFull), 32'd0);
    check("R1 overflow", 32'(overflow), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge sysClk);

    // R11: pop on an empty queue leaves the count at zero
    popReq = 1'b1;
    @(negedge sysClk);
    popReq = 1'b0;
    @(negedge sysClk);
    check("R11 level after empty pop", 32'(fifoLevel), 32'd0);
    check("R11 empty after empty pop", 32'(fifoEmpty), 32'd1);

    // table: one fresh lane per entry, widths R2, layout R3/R4, framing R5/R6
    for (int v = 0; v < 8; v++) begin
      logic [2:0] ch;
      logic [1:0] md;
      logic [23:0] lv, rv;
      int n;
      {ch, md, lv, rv} = VEC[v];
      n = widthOf(md);
      ctrlWord = '0;
      ctrlWord[8 + 3*ch +: 3] = {1'b0, md};
      ctrlWord[7:0] = 8'hA5;  // R2: low byte has no effect
      frame(8'(1) << ch, lv, rv, n);
      @(negedge sysClk);
      check("R6 two words only", 32'(fifoLevel), 32'd2);
      popCheck("R2 R3 R4 R5 left word", expWord(lv, n, 1'b1, ch));
      popCheck("R2 R3 R4 R5 right word", expWord(rv, n, 1'b0, ch));
    end

    // R7: disabled code on lane 0
    ctrlWord = '0;
    ctrlWord[10:8] = 3'd6;
    frame(8'h01, 24'h111111, 24'h222222, 24);
    @(negedge sysClk);
    check("R7 disabled lane level", 32'(fifoLevel), 32'd0);

    // R8/R9: all lanes finish together, fill the queue exactly
    ctrlWord = '0;
    frame(8'hFF, 24'h123456, 24'hABCDEF, 24);
    @(negedge sysClk);
    check("R9 level full", 32'(fifoLevel), 32'd16);
    check("R9 full flag", 32'(fifoFull), 32'd1);
    check("R10 no overflow yet", 32'(overflow), 32'd0);

    // R10: another round arrives while full
    frame(8'hFF, 24'h555555, 24'h999999, 24);
    @(negedge sysClk);
    check("R10 overflow set", 32'(overflow), 32'd1);
    check("R10 level unchanged", 32'(fifoLevel), 32'd16);

    for (int c = 0; c < 8; c++)
      popCheck("R8 R10 left order", expWord(24'h123456, 24, 1'b1, 3'(c)));
    for (int c = 0; c < 8; c++)
      popCheck("R8 R10 right order", expWord(24'hABCDEF, 24, 1'b0, 3'(c)));
    @(negedge sysClk);
    check("R9 drained", 32'(fifoEmpty), 32'd1);
    check("R10 overflow sticky", 32'(overflow), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule